// File: doc/BRIEF.md
# Modem Control Output and Interrupt Gating

This block serves one serial channel. A byte-wide control register, loaded through a simple write port, drives the channel's outputs. The request-to-send line is active low and follows one bit of the register. A second bit does two jobs at once. It turns the interrupt pin driver on or off, which is presented as a value plus an output enable. It also drives the active-low general-purpose output 2 to the opposite level. Because that one bit serves both functions, a system uses either the interrupt pin or output 2, not both.

The block also watches the active-low ring-indicator input. The input passes through a two-flop synchroniser. When the line goes from low to high, the block sets a sticky ring-change flag. The flag stays set until a status-read strobe clears it. When the modem-status interrupt enable is high, the flag is ORed into the interrupt pin value together with the channel's internal interrupt request.

Two resets return every register to its default. The first is the asynchronous active-low master reset. The second is a synchronous reset that fires when the low-power input is released, meaning a clock edge that samples it low after it was high.

Top module: `modem_ctl_gate`

## Requirements
- R1: When control bit 3 is 1, irq_oe_o is 1 and op2_no is 0. When bit 3 is 0, irq_oe_o is 0 and op2_no is 1.
- R2: rts_no equals the inverse of control bit 1. A write updates rts_no, op2_no and irq_oe_o on the clock edge that samples mcr_we_i high. Without a write, these outputs hold.
- R3: While rst_ni is low, the control register is 0x00 and the ring-change flag is clear. The outputs are then rts_no=1, op2_no=1, irq_oe_o=0 and ri_chg_o=0.
- R4: A low-to-high change of ri_ni sets ri_chg_o on the third clock edge after ri_ni first holds its new value at an edge. A high-to-low change never sets the flag.
- R5: Once set, ri_chg_o stays set until a clock edge samples ms_rd_i high, which clears it. If a new rising ring event and the read strobe arrive on the same edge, the flag ends up set.
- R6: irq_o is the OR of irq_req_i and (ri_chg_o AND ms_ie_i). This is combinational.
- R7: A clock edge that samples lp_i low, when the previous edge sampled it high, resets the control register, the ring synchroniser and the flag to their defaults. A control write on that same edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| lp_i | input | 1 | Low-power request; its release forces a register reset |
| mcr_we_i | input | 1 | Control register write enable |
| mcr_wdata_i | input | 8 | Control register write data |
| irq_req_i | input | 1 | Channel's internal interrupt request |
| ms_ie_i | input | 1 | Modem-status interrupt enable |
| ms_rd_i | input | 1 | Status read strobe; clears the ring-change flag |
| ri_ni | input | 1 | Ring indicator, active low, asynchronous |
| rts_no | output | 1 | Request to send, active low |
| op2_no | output | 1 | General-purpose output 2, active low |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe_o | output | 1 | Interrupt pin output enable |
| ri_chg_o | output | 1 | Sticky ring-change flag |

## Verification
The assertions assume that lp_i, mcr_we_i, mcr_wdata_i and ms_rd_i are synchronous to clk_i. The low-power release is therefore detected from two consecutive edge samples. Only ri_ni may change freely, and it is always resynchronised first. The bench changes every input half a period away from the rising edge, at the falling edge. It releases lp_i only after holding it high for at least one edge. It toggles ri_ni at random so that rises, falls, single-cycle pulses, read-strobe collisions and releases into low power all occur.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;
  localparam int unsigned MCR_W    = 8;
  localparam int unsigned RTS_BIT  = 1;
  localparam int unsigned OUT2_BIT = 3;
  localparam int unsigned SYNC_N   = 2;
  typedef logic [MCR_W-1:0] mcr_t;
  localparam mcr_t MCR_RST = '0;
endpackage

// File: rtl/mcr_reg.sv
module mcr_reg
  import modem_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic we_i,
  input  mcr_t wdata_i,
  output mcr_t mcr_o
);
  mcr_t mcr_q;

  // soft clear beats a write on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mcr_q <= MCR_RST;
    else if (clr_i) mcr_q <= MCR_RST;
    else if (we_i)  mcr_q <= wdata_i;
  end

  assign mcr_o = mcr_q;
endmodule

// File: rtl/lp_exit_det.sv
module lp_exit_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_i,
  output logic exit_o
);
  logic lp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_q <= 1'b0;
    else         lp_q <= lp_i;
  end

  assign exit_o = lp_q & ~lp_i;
endmodule

// File: rtl/ri_edge.sv
module ri_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ri_ni,
  input  logic rd_i,
  output logic flag_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              flag_q;
  logic              rise;

  // synchroniser stages reset to the idle (high) level of the line
  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    logic d;
    if (g == 0) begin : g_first
      assign d = ri_ni;
    end else begin : g_next
      assign d = sync_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sync_q[g] <= 1'b1;
      else if (clr_i) sync_q[g] <= 1'b1;
      else            sync_q[g] <= d;
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else if (clr_i) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sync_q[LAST];
      if (rise)      flag_q <= 1'b1;  // new event wins over a read
      else if (rd_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/out_gate.sv
module out_gate
  import modem_ctl_pkg::*;
(
  input  mcr_t mcr_i,
  input  logic irq_req_i,
  input  logic ms_flag_i,
  input  logic ms_ie_i,
  output logic rts_no,
  output logic op2_no,
  output logic irq_o,
  output logic irq_oe_o
);
  assign rts_no   = ~mcr_i[RTS_BIT];
  assign op2_no   = ~mcr_i[OUT2_BIT];
  assign irq_oe_o =  mcr_i[OUT2_BIT];
  assign irq_o    = irq_req_i | (ms_flag_i & ms_ie_i);
endmodule

// File: rtl/modem_ctl_gate.sv
module modem_ctl_gate
  import modem_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lp_i,
  input  logic             mcr_we_i,
  input  logic [MCR_W-1:0] mcr_wdata_i,
  input  logic             irq_req_i,
  input  logic             ms_ie_i,
  input  logic             ms_rd_i,
  input  logic             ri_ni,
  output logic             rts_no,
  output logic             op2_no,
  output logic             irq_o,
  output logic             irq_oe_o,
  output logic             ri_chg_o
);
  logic soft_clr;
  mcr_t mcr;
  logic ri_flag;

  lp_exit_det u_lp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lp_i   (lp_i),
    .exit_o (soft_clr)
  );

  mcr_reg u_mcr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_clr),
    .we_i    (mcr_we_i),
    .wdata_i (mcr_wdata_i),
    .mcr_o   (mcr)
  );

  ri_edge #(.STAGES(SYNC_STAGES)) u_ri (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_clr),
    .ri_ni  (ri_ni),
    .rd_i   (ms_rd_i),
    .flag_o (ri_flag)
  );

  out_gate u_out (
    .mcr_i     (mcr),
    .irq_req_i (irq_req_i),
    .ms_flag_i (ri_flag),
    .ms_ie_i   (ms_ie_i),
    .rts_no    (rts_no),
    .op2_no    (op2_no),
    .irq_o     (irq_o),
    .irq_oe_o  (irq_oe_o)
  );

  assign ri_chg_o = ri_flag;
endmodule

// File: rtl/modem_ctl_gate_chk.sv
module modem_ctl_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lp_i,
  input logic       mcr_we_i,
  input logic [7:0] mcr_wdata_i,
  input logic       irq_req_i,
  input logic       ms_ie_i,
  input logic       ms_rd_i,
  input logic       ri_ni,
  input logic       rts_no,
  input logic       op2_no,
  input logic       irq_o,
  input logic       irq_oe_o,
  input logic       ri_chg_o
);
  logic lp_d;
  logic lp_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_d <= 1'b0;
    else         lp_d <= lp_i;
  end
  assign lp_x = lp_d && !lp_i;

  p_out2_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcr_we_i && !lp_x) |=> (op2_no == !$past(mcr_wdata_i[3])) && (irq_oe_o == $past(mcr_wdata_i[3])));

  p_rts_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcr_we_i && !lp_x) |=> (rts_no == !$past(mcr_wdata_i[1])));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mcr_we_i && !lp_x) |=> $stable(rts_no) && $stable(op2_no) && $stable(irq_oe_o));

  p_reset_r3: assert property (@(posedge clk_i)
    !rst_ni |-> (rts_no && op2_no && !irq_oe_o && !ri_chg_o));

  // default two-stage synchroniser: rise seen three edges after the input
  p_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ri_chg_o) |-> ($past(ri_ni, 3) && !$past(ri_ni, 4)));

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_chg_o && !ms_rd_i && !lp_x) |=> ri_chg_o);

  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i |-> irq_o);

  p_irq_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_i && !ms_ie_i) |-> !irq_o);

  p_lp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_x |=> (rts_no && op2_no && !irq_oe_o && !ri_chg_o));
endmodule

bind modem_ctl_gate modem_ctl_gate_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lp_i        (lp_i),
  .mcr_we_i    (mcr_we_i),
  .mcr_wdata_i (mcr_wdata_i),
  .irq_req_i   (irq_req_i),
  .ms_ie_i     (ms_ie_i),
  .ms_rd_i     (ms_rd_i),
  .ri_ni       (ri_ni),
  .rts_no      (rts_no),
  .op2_no      (op2_no),
  .irq_o       (irq_o),
  .irq_oe_o    (irq_oe_o),
  .ri_chg_o    (ri_chg_o)
);

// File: tb/modem_ctl_gate_tb_top.sv
module modem_ctl_gate_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lp_i = 1'b0;
  logic       mcr_we_i = 1'b0;
  logic [7:0] mcr_wdata_i = '0;
  logic       irq_req_i = 1'b0;
  logic       ms_ie_i = 1'b0;
  logic       ms_rd_i = 1'b0;
  logic       ri_ni = 1'b1;
  logic       rts_no, op2_no, irq_o, irq_oe_o, ri_chg_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  // bench model state
  logic [7:0] m_mcr;
  logic       m_s0, m_s1, m_prev, m_flag, m_lpq;

  always #5 clk_i = ~clk_i;

  modem_ctl_gate dut_i (.*);

  task automatic model_reset();
    m_mcr = 8'h00; m_s0 = 1'b1; m_s1 = 1'b1; m_prev = 1'b1; m_flag = 1'b0; m_lpq = 1'b0;
  endtask

  // one rising edge of the requirement model (R2, R4, R5, R7)
  task automatic model_edge();
    logic rise;
    logic lpx;
    rise = m_s1 & ~m_prev;
    lpx  = m_lpq & ~lp_i;
    if (lpx) begin
      m_mcr = 8'h00; m_s0 = 1'b1; m_s1 = 1'b1; m_prev = 1'b1; m_flag = 1'b0;
    end else begin
      if (mcr_we_i) m_mcr = mcr_wdata_i;
      if (rise) m_flag = 1'b1;
      else if (ms_rd_i) m_flag = 1'b0;
      m_prev = m_s1; m_s1 = m_s0; m_s0 = ri_ni;
    end
    m_lpq = lp_i;
  endtask

  function automatic logic exp_irq();
    return irq_req_i | (m_flag & ms_ie_i);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string ctx);
    chk(rts_no,   ~m_mcr[1], {"R2 rts ", ctx});
    chk(op2_no,   ~m_mcr[3], {"R1 op2 ", ctx});
    chk(irq_oe_o,  m_mcr[3], {"R1 oe ", ctx});
    chk(ri_chg_o,  m_flag,   {"R4/R5 flag ", ctx});
    chk(irq_o,     exp_irq(), {"R6 irq ", ctx});
  endtask

  // inputs already set at a falling edge; advance one cycle and compare
  task automatic step(input string ctx);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_all(ctx);
  endtask

  task automatic idle_inputs();
    mcr_we_i = 1'b0; ms_rd_i = 1'b0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    check_all("R3 in reset");
    rst_ni = 1'b1;
    step("after reset");

    // R1/R2 directed: bit1 and bit3 set
    mcr_we_i = 1'b1; mcr_wdata_i = 8'h0A; step("R1 R2 write 0A");
    idle_inputs(); step("R2 hold");
    mcr_we_i = 1'b1; mcr_wdata_i = 8'hF5; step("R1 R2 write F5");
    idle_inputs();

    // R4: rise on ring line, flag after three edges
    ri_ni = 1'b0; repeat (4) step("R4 ri low");
    ri_ni = 1'b1; step("R4 edge1"); step("R4 edge2");
    chk(ri_chg_o, 1'b0, "R4 not yet at edge2");
    step("R4 edge3");
    chk(ri_chg_o, 1'b1, "R4 set at edge3");
    // R6: enable routes the flag to irq
    ms_ie_i = 1'b1; step("R6 ie on");
    chk(irq_o, 1'b1, "R6 flag to irq");
    ms_ie_i = 1'b0; step("R6 ie off");
    // R5: read clears
    ms_rd_i = 1'b1; step("R5 read"); ms_rd_i = 1'b0;
    chk(ri_chg_o, 1'b0, "R5 cleared");
    // R4: falling does not set
    ri_ni = 1'b0; repeat (5) step("R4 fall");
    chk(ri_chg_o, 1'b0, "R4 fall no flag");
    // R5: read on the same edge as the rise
    ri_ni = 1'b1; step("R5 c1"); step("R5 c2");
    ms_rd_i = 1'b1; step("R5 collide"); ms_rd_i = 1'b0;
    chk(ri_chg_o, 1'b1, "R5 set wins");

    // R7: low-power release clears, write on same edge dropped
    mcr_we_i = 1'b1; mcr_wdata_i = 8'h0A; step("R7 pre");
    idle_inputs(); lp_i = 1'b1; step("R7 lp high");
    lp_i = 1'b0; mcr_we_i = 1'b1; mcr_wdata_i = 8'hFF; step("R7 exit");
    idle_inputs();
    chk(rts_no, 1'b1, "R7 rts default");
    chk(ri_chg_o, 1'b0, "R7 flag cleared");

    // R3: asynchronous reset mid-run
    mcr_we_i = 1'b1; mcr_wdata_i = 8'h0A; step("R3 pre"); idle_inputs();
    #2 rst_ni = 1'b0; #1;
    model_reset();
    check_all("R3 async");
    @(negedge clk_i); rst_ni = 1'b1;
    step("R3 release");

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      mcr_we_i    = ($urandom % 4) == 0;
      mcr_wdata_i = 8'($urandom);
      irq_req_i   = ($urandom % 5) == 0;
      ms_ie_i     = ($urandom % 2) == 0;
      ms_rd_i     = ($urandom % 6) == 0;
      if (($urandom % 3) == 0) ri_ni = ~ri_ni;
      if (($urandom % 40) == 0) lp_i = ~lp_i;
      step("random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule